// File: doc/BRIEF.md
# Address-Event Sender Emulator

This block stands in for an event sensor on a two-word asynchronous address-event link. A receiver can then be brought up on a board without the real camera attached. Events arrive on a valid/ready input as a row (Y) address, a column (X) address and a polarity bit. Each event is sent as two words, Y first and then X with polarity. A word-select line tags each word, and each word has its own four-phase handshake. The request line is an active-low output of this block. The acknowledge line is an active-low input driven by the receiver under test.

For each word, the select line and the 9-bit bus take their new values a programmable number of clock cycles before request falls. They hold until the receiver has acknowledged. Acknowledge is resynchronised before the state machine uses it. Events whose address is outside the 240-column by 180-row array are never sent. Instead, a saturating counter records them.

Top module: `aer_event_sender`

## Requirements
- R1: After synchronous active-high reset, `aer_req_n` is 1, `aer_sel` is 0, `in_ready` is 1 and `err_count` is 0.
- R2: The first word of an event has `aer_sel` = 0, `aer_data[7:0]` = Y address and `aer_data[8]` = 0.
- R3: The second word of an event has `aer_sel` = 1, `aer_data[8:1]` = X address and `aer_data[0]` = polarity.
- R4: The second word's request does not assert until the first word's handshake has finished: request released and acknowledge seen high again. `aer_sel` only changes while `aer_req_n` is 1.
- R5: `aer_data` and `aer_sel` hold their value for at least `SETUP_CYC` clock cycles before `aer_req_n` falls. They stay unchanged for as long as `aer_req_n` is 0.
- R6: Once asserted, `aer_req_n` stays 0 until the receiver drives `aer_ack_n` to 0. After that, it returns to 1.
- R7: After request is released, the block starts nothing new (neither the next word nor a new event) until `aer_ack_n` has returned to 1.
- R8: `in_ready` is 1 only while the sender is idle with `aer_req_n` at 1. It is 0 from the cycle an event is accepted until that event's second handshake completes.
- R9: An offered event with Y > 179 or X > 239 is consumed in one cycle and produces no request. It raises `err_count` by one.
- R10: `err_count` saturates at its all-ones value (255 by default) and does not wrap.
- R11: The boundary event Y = 179, X = 239 is in range and is sent normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Event offered |
| in_ready | output | 1 | Sender idle and able to take an event |
| in_y | input | 8 | Row address of the offered event |
| in_x | input | 8 | Column address of the offered event |
| in_pol | input | 1 | Polarity of the offered event |
| aer_req_n | output | 1 | Link request, active low |
| aer_sel | output | 1 | Word select: 0 = Y word, 1 = X/polarity word |
| aer_data | output | 9 | Link data bus |
| aer_ack_n | input | 1 | Receiver acknowledge, active low, asynchronous |
| err_count | output | 8 | Saturating count of dropped out-of-range events |

## Verification
The assertions assume that the receiver obeys the four-phase protocol. It pulls acknowledge low only while request is low, and it releases acknowledge only after request has gone high again. They also assume that acknowledge holds each level long enough to pass the two-stage synchronizer. The bench's receiver model keeps to this: it changes `aer_ack_n` only on falling clock edges, only in response to the request level it has observed, and holds every level for several cycles. Input events are offered only on falling edges and are withdrawn right after the accepting edge.

// File: rtl/aer_sender_pkg.sv
package aer_sender_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WAIT_ACK,
        ST_WAIT_REL
    } aer_state_e;

endpackage

// File: rtl/aer_ack_sync.sv
module aer_ack_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= {STAGES{RST_VAL}};
        else     sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/aer_range_check.sv
module aer_range_check #(
    parameter int ADDR_W = 8,
    parameter int X_MAX  = 239,
    parameter int Y_MAX  = 179
) (
    input  logic [ADDR_W-1:0] y,
    input  logic [ADDR_W-1:0] x,
    output logic              in_range
);
    localparam logic [ADDR_W-1:0] X_LIM = ADDR_W'(X_MAX);
    localparam logic [ADDR_W-1:0] Y_LIM = ADDR_W'(Y_MAX);

    assign in_range = (y <= Y_LIM) && (x <= X_LIM);
endmodule

// File: rtl/aer_err_counter.sv
module aer_err_counter #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [ERR_W-1:0] count
);
    localparam logic [ERR_W-1:0] TOP = {ERR_W{1'b1}};

    logic [ERR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != TOP) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R10
    err_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == TOP) |=> (cnt_q == TOP));

    // R9
    err_step_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/aer_event_sender.sv
module aer_event_sender
    import aer_sender_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int X_MAX       = 239,
    parameter int Y_MAX       = 179,
    parameter int SETUP_CYC   = 4,
    parameter int SYNC_STAGES = 2,
    parameter int ERR_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_y,
    input  logic [ADDR_W-1:0] in_x,
    input  logic              in_pol,
    output logic              aer_req_n,
    output logic              aer_sel,
    output logic [ADDR_W:0]   aer_data,
    input  logic              aer_ack_n,
    output logic [ERR_W-1:0]  err_count
);
    localparam int DATA_W = ADDR_W + 1;
    localparam int CNT_W  = (SETUP_CYC < 2) ? 1 : $clog2(SETUP_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETUP_CYC - 1);

    typedef struct packed {
        aer_state_e        st;
        logic              word_x;
        logic [CNT_W-1:0]  cnt;
        logic              req_n;
        logic              sel;
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] x;
        logic              pol;
    } regs_t;

    regs_t d, q;
    logic  ack_s;
    logic  in_ok;
    logic  drop;

    aer_ack_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) ack_sync_i (
        .clk (clk),
        .rst (rst),
        .din (aer_ack_n),
        .dout(ack_s)
    );

    aer_range_check #(.ADDR_W(ADDR_W), .X_MAX(X_MAX), .Y_MAX(Y_MAX)) range_i (
        .y       (in_y),
        .x       (in_x),
        .in_range(in_ok)
    );

    aer_err_counter #(.ERR_W(ERR_W)) err_i (
        .clk  (clk),
        .rst  (rst),
        .inc  (drop),
        .count(err_count)
    );

    always_comb begin
        d    = q;
        drop = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    if (in_ok) begin
                        d.st     = ST_SETUP;
                        d.word_x = 1'b0;
                        d.cnt    = '0;
                        d.sel    = 1'b0;
                        d.data   = {1'b0, in_y};
                        d.x      = in_x;
                        d.pol    = in_pol;
                    end else begin
                        drop = 1'b1;
                    end
                end
            end
            ST_SETUP: begin
                if (q.cnt == CNT_LAST) begin
                    d.req_n = 1'b0;
                    d.st    = ST_WAIT_ACK;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_WAIT_ACK: begin
                if (!ack_s) begin
                    d.req_n = 1'b1;
                    d.st    = ST_WAIT_REL;
                end
            end
            ST_WAIT_REL: begin
                if (ack_s) begin
                    if (!q.word_x) begin
                        d.word_x = 1'b1;
                        d.sel    = 1'b1;
                        d.data   = {q.x, q.pol};
                        d.cnt    = '0;
                        d.st     = ST_SETUP;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st     <= ST_IDLE;
            q.word_x <= 1'b0;
            q.cnt    <= '0;
            q.req_n  <= 1'b1;
            q.sel    <= 1'b0;
            q.data   <= '0;
            q.x      <= '0;
            q.pol    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign in_ready  = (q.st == ST_IDLE);
    assign aer_req_n = q.req_n;
    assign aer_sel   = q.sel;
    assign aer_data  = q.data;

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!aer_req_n && $past(!aer_req_n)) |-> ($stable(aer_data) && $stable(aer_sel)));

    // R6
    req_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(aer_req_n) |-> !$past(ack_s));

    // R7
    req_assert_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(aer_req_n) |-> $past(ack_s));

    // R4
    sel_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(aer_sel) |-> (aer_req_n && $past(aer_req_n)));

    // R8
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> aer_req_n);

    // R9
    drop_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !in_ok) |=> (aer_req_n && in_ready));
endmodule

// File: tb/aer_event_sender_tb_top.sv
module aer_event_sender_tb_top;
    localparam int SETUP_CYC = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_y = '0;
    logic [7:0] in_x = '0;
    logic       in_pol = 1'b0;
    logic       aer_req_n;
    logic       aer_sel;
    logic [8:0] aer_data;
    logic       aer_ack_n = 1'b1;
    logic [7:0] err_count;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    aer_event_sender #(.SETUP_CYC(SETUP_CYC)) dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_y(in_y), .in_x(in_x), .in_pol(in_pol),
        .aer_req_n(aer_req_n), .aer_sel(aer_sel), .aer_data(aer_data),
        .aer_ack_n(aer_ack_n), .err_count(err_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_event(input logic [7:0] y, input logic [7:0] x, input logic p);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_y = y; in_x = x; in_pol = p;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Receiver model for one word; returns what was seen when request fell.
    task automatic recv_word(input int ack_dly, input int rel_dly,
                             output logic sel_o, output logic [8:0] data_o);
        logic [8:0] pd;
        logic       ps;
        int         stab = 0;
        int         tmo  = 0;
        bit         moved = 0;
        pd = aer_data; ps = aer_sel;
        while (aer_req_n && tmo < 300) begin
            @(negedge clk);
            tmo++;
            if (aer_data !== pd || aer_sel !== ps) stab = 0; else stab++;
            pd = aer_data; ps = aer_sel;
        end
        chk(aer_req_n == 1'b0, "R6 request asserted", aer_req_n, 0);
        chk(stab >= SETUP_CYC, "R5 setup before request", stab, SETUP_CYC);
        sel_o = aer_sel; data_o = aer_data;
        for (int i = 0; i < ack_dly; i++) begin
            @(negedge clk);
            if (aer_data !== pd || aer_sel !== ps || aer_req_n) moved = 1;
        end
        chk(!moved, "R6 request held without ack", moved, 0);
        aer_ack_n = 1'b0;
        tmo = 0;
        while (!aer_req_n && tmo < 300) begin
            @(negedge clk);
            tmo++;
            if (!aer_req_n && (aer_data !== pd || aer_sel !== ps)) moved = 1;
        end
        chk(aer_req_n == 1'b1 && !moved, "R5 R6 stable then released", moved, 0);
        moved = 0;
        for (int i = 0; i < rel_dly; i++) begin
            @(negedge clk);
            if (!aer_req_n || aer_sel !== ps || in_ready) moved = 1;
        end
        chk(!moved, "R7 nothing starts before ack release", moved, 0);
        aer_ack_n = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(aer_req_n == 1'b1, "R1 req_n", aer_req_n, 1);
        chk(aer_sel == 1'b0, "R1 sel", aer_sel, 0);
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        chk(err_count == 8'd0, "R1 err_count", err_count, 0);
    endtask

    task automatic t_event(input logic [7:0] y, input logic [7:0] x, input logic p,
                           input int ack_dly, input int rel_dly, input string tag);
        logic       s;
        logic [8:0] dw;
        logic [7:0] e0;
        int         tmo = 0;
        e0 = err_count;
        send_event(y, x, p);
        chk(in_ready == 1'b0, {tag, " R8 busy after accept"}, in_ready, 0);
        recv_word(ack_dly, rel_dly, s, dw);
        chk(s == 1'b0, {tag, " R2 Y word select"}, s, 0);
        chk(dw == {1'b0, y}, {tag, " R2 Y word data"}, dw, {1'b0, y});
        chk(in_ready == 1'b0, {tag, " R8 busy between words"}, in_ready, 0);
        recv_word(ack_dly, rel_dly, s, dw);
        chk(s == 1'b1, {tag, " R3 R4 X word select second"}, s, 1);
        chk(dw == {x, p}, {tag, " R3 X word data"}, dw, {x, p});
        while (!in_ready && tmo < 50) begin @(negedge clk); tmo++; end
        chk(in_ready == 1'b1 && aer_req_n == 1'b1, {tag, " R8 idle again"}, in_ready, 1);
        chk(err_count == e0, {tag, " R9 no error for valid event"}, err_count, e0);
    endtask

    task automatic t_drop(input logic [7:0] y, input logic [7:0] x, input string tag);
        logic [7:0] e0;
        bit         req_seen = 0;
        e0 = err_count;
        send_event(y, x, 1'b1);
        chk(err_count == e0 + 8'd1, {tag, " R9 error counted"}, err_count, e0 + 8'd1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!aer_req_n || !in_ready) req_seen = 1;
        end
        chk(!req_seen, {tag, " R9 no request for dropped event"}, req_seen, 0);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_y = 8'd200; in_x = 8'd0;
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(err_count == 8'hFF, "R10 counter saturated", err_count, 255);
        chk(aer_req_n == 1'b1, "R10 R9 no request during drops", aer_req_n, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_event(8'd0,   8'd0,   1'b0, 3, 3,  "zero");
        t_event(8'd179, 8'd239, 1'b1, 3, 3,  "R11 boundary");
        t_event(8'd100, 8'd37,  1'b1, 30, 20, "slow ack");
        t_event(8'hA5,  8'h5A,  1'b0, 1, 1,  "alternating bits");
        t_drop(8'd180, 8'd10,  "Y out of range");
        t_drop(8'd5,   8'd240, "X out of range");
        t_event(8'd12,  8'd200, 1'b1, 2, 4,  "after drops");
        t_saturate();
        t_event(8'd1,   8'd2,   1'b0, 2, 2,  "after saturation");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule